// File: doc/BRIEF.md
# Asynchronous Static RAM Bus Controller

This block sits between a clocked request interface inside the chip and an external byte-wide asynchronous static RAM of 256K locations. An internal agent offers one access at a time: a read or write flag, an 18-bit address and, for writes, one data byte. Requests use a valid/ready handshake. The controller turns each accepted request into a pin sequence of chip select, output enable and write enable. That sequence is sized in whole clock cycles, so the memory's address setup, write-pulse, data-setup and bus-turnaround limits are all met. Read data comes back on a registered byte with a one-cycle valid strobe.

The cycle counts come from the clock period and the memory's timing limits, each rounded up. During writes the controller holds output enable high, so the shorter write-pulse limit applies. It turns on its own data drivers only after the memory has had time to float the bus, and it turns them off on the same edge that ends the write. After every access comes one cycle with chip select high before the next request can be taken.

The data bus is split into an outgoing byte, a drive-enable and an incoming byte. The pad ring joins them into one tri-state pin group.

Top module: `sram_bus_ctrl`

## Requirements
- R1: While reset is asserted and in the first cycle after it, reqReady is 1, sramCeN, sramOeN and sramWeN are 1, sramDqOe is 0 and rspValid is 0.
- R2: A request is taken only on a clock edge where reqValid and reqReady are both 1. reqReady is 0 from the cycle after acceptance until the access, including its closing idle cycle, is over. reqValid and the request fields seen in that time have no effect on the pins or the response.
- R3: A write (reqWrite=1) drives the address with sramCeN=0 and sramWeN=1 for SETUP_CYC cycles. It then holds sramWeN=0 for exactly WE_CYC cycles. sramOeN stays 1 for the whole write.
- R4: In a write, sramDqOe is 1 only in the cycles of the write-enable pulse whose index (counting from 0) is at least TURN_CYC. sramDqOe falls in the same cycle that sramWeN rises. While driven, sramDqOut equals the accepted write byte.
- R5: A read (reqWrite=0) holds sramCeN=0 and sramOeN=0 for exactly RD_CYC cycles. sramWeN stays 1 for the whole read and sramDqOe stays 0.
- R6: The byte on sramDqIn at the clock edge that ends the read is returned on rspData. rspValid is 1 for exactly the one cycle that follows.
- R7: Every access is followed by exactly one cycle with sramCeN, sramOeN and sramWeN all 1 and reqReady 0. reqReady is 1 again in the cycle after that, so requests held back to back are separated by that one cycle.
- R8: sramAddr equals the accepted address, and does not change, for every cycle of an access in which sramCeN is 0.
- R9: The counts are derived by rounding up to whole clock periods. TURN_CYC is the bus release time (4 ns). WE_CYC is the larger of the write-pulse minimum (7 ns) and TURN_CYC plus the data setup (5 ns). SETUP_CYC is the address-to-write-end minimum (8 ns) less WE_CYC, but at least 1. RD_CYC is the access time (10 ns) plus one cycle. At an 8 ns clock this gives SETUP_CYC=1, WE_CYC=2, TURN_CYC=1 and RD_CYC=3.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| reqValid | input | 1 | Request offered |
| reqReady | output | 1 | Controller idle and able to accept |
| reqWrite | input | 1 | 1 = write, 0 = read |
| reqAddr | input | 18 | Memory address |
| reqWdata | input | 8 | Write byte |
| rspValid | output | 1 | One-cycle read-data strobe |
| rspData | output | 8 | Returned read byte |
| sramAddr | output | 18 | Memory address pins |
| sramCeN | output | 1 | Active-low chip select |
| sramOeN | output | 1 | Active-low output enable |
| sramWeN | output | 1 | Active-low write enable |
| sramDqOut | output | 8 | Byte to drive on the data pins |
| sramDqOe | output | 1 | Drive enable for the data pins |
| sramDqIn | input | 8 | Byte sensed on the data pins |

## Verification
Acceptance happens on the edge where reqValid and reqReady are both high. The first access cycle, with chip select low, is the cycle after that edge. From there the bench reference model lays out the exact expected pin state of every later cycle: SETUP_CYC plus WE_CYC write cycles or RD_CYC read cycles, then the single closing cycle, which carries rspValid and the byte for a read. The model queues one expected entry per cycle and pops one per rising edge. It compares all outputs at the falling edge, when everything has settled, so a pin that changes one cycle early or late is a mismatch in that cycle. The memory behind the pins is modelled as well, so a byte written over the pins and then read back through them is checked end to end.

// File: rtl/sram_ctrl_pkg.sv
package sram_ctrl_pkg;

  // Strobes from the sequencer to the datapath
  typedef struct packed {
    logic loadReq;   // latch request address and write byte
    logic capture;   // register the byte sensed on the data pins
    logic driveEn;   // enable the outgoing data drivers
  } dpStrobe_t;

  // Round a picosecond interval up to whole clock periods
  function automatic int cyclesFor(input int intervalPs, input int periodPs);
    return (intervalPs + periodPs - 1) / periodPs;
  endfunction

endpackage

// File: rtl/sram_ctrl_fsm.sv
module sram_ctrl_fsm
  import sram_ctrl_pkg::*;
#(
  parameter int SETUP_CYC = 1,
  parameter int WE_CYC    = 2,
  parameter int TURN_CYC  = 1,
  parameter int RD_CYC    = 2
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       reqValid,
  input  logic       reqWrite,
  output logic       reqReady,
  output logic       sramCeN,
  output logic       sramOeN,
  output logic       sramWeN,
  output dpStrobe_t  strobe
);

  localparam int MAXC1 = (SETUP_CYC > WE_CYC) ? SETUP_CYC : WE_CYC;
  localparam int MAXC  = (MAXC1 > RD_CYC) ? MAXC1 : RD_CYC;
  localparam int CNT_W = (MAXC > 1) ? $clog2(MAXC) : 1;

  typedef enum logic [2:0] {
    S_IDLE, S_SETUP, S_PULSE, S_READ, S_GAP
  } seqState_t;

  seqState_t state;
  logic [CNT_W-1:0] cnt;
  logic cntDone;

  assign cntDone = (cnt == '0);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state <= S_IDLE;
      cnt   <= '0;
    end else begin
      case (state)
        S_IDLE: if (reqValid) begin
          if (reqWrite) begin
            state <= S_SETUP;
            cnt   <= CNT_W'(SETUP_CYC - 1);
          end else begin
            state <= S_READ;
            cnt   <= CNT_W'(RD_CYC - 1);
          end
        end
        S_SETUP: if (cntDone) begin
          state <= S_PULSE;
          cnt   <= CNT_W'(WE_CYC - 1);
        end else begin
          cnt <= cnt - 1'b1;
        end
        S_PULSE, S_READ: if (cntDone) begin
          state <= S_GAP;
        end else begin
          cnt <= cnt - 1'b1;
        end
        default: state <= S_IDLE;
      endcase
    end
  end

  always_comb begin
    reqReady       = (state == S_IDLE);
    sramCeN        = !(state == S_SETUP || state == S_PULSE || state == S_READ);
    sramOeN        = (state != S_READ);
    sramWeN        = (state != S_PULSE);
    strobe.loadReq = (state == S_IDLE) && reqValid;
    strobe.capture = (state == S_READ) && cntDone;
    // counter runs down, so pulse index >= TURN_CYC means cnt < WE_CYC-TURN_CYC
    strobe.driveEn = (state == S_PULSE) && (cnt < CNT_W'(WE_CYC - TURN_CYC));
  end

  // R5: write enable and output enable are never low together
  assert_no_we_oe_overlap_R5: assert property (@(posedge clk) disable iff (!rstN)
    !(!sramWeN && !sramOeN));

  // R7: chip select stays high for the cycle after it rises
  assert_gap_cycle_R7: assert property (@(posedge clk) disable iff (!rstN)
    $rose(sramCeN) |=> (sramCeN && !strobe.loadReq) || sramCeN);

  // R2: no acceptance while the memory is selected
  assert_ready_busy_R2: assert property (@(posedge clk) disable iff (!rstN)
    !sramCeN |-> !reqReady);

endmodule

// File: rtl/sram_ctrl_datapath.sv
module sram_ctrl_datapath
  import sram_ctrl_pkg::*;
#(
  parameter int ADDR_W = 18,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  dpStrobe_t         strobe,
  input  logic [ADDR_W-1:0] reqAddr,
  input  logic [DATA_W-1:0] reqWdata,
  input  logic [DATA_W-1:0] sramDqIn,
  output logic [ADDR_W-1:0] sramAddr,
  output logic [DATA_W-1:0] sramDqOut,
  output logic              sramDqOe,
  output logic              rspValid,
  output logic [DATA_W-1:0] rspData
);

  logic [ADDR_W-1:0] addrQ;
  logic [DATA_W-1:0] wdataQ;
  logic [DATA_W-1:0] rdataQ;
  logic              rspValidQ;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      addrQ     <= '0;
      wdataQ    <= '0;
      rdataQ    <= '0;
      rspValidQ <= 1'b0;
    end else begin
      if (strobe.loadReq) begin
        addrQ  <= reqAddr;
        wdataQ <= reqWdata;
      end
      if (strobe.capture) rdataQ <= sramDqIn;
      rspValidQ <= strobe.capture;
    end
  end

  assign sramAddr  = addrQ;
  assign sramDqOut = wdataQ;
  assign sramDqOe  = strobe.driveEn;
  assign rspValid  = rspValidQ;
  assign rspData   = rdataQ;

  // R6: the response strobe lasts a single cycle
  assert_rsp_single_R6: assert property (@(posedge clk) disable iff (!rstN)
    rspValid |=> !rspValid);

endmodule

// File: rtl/sram_bus_ctrl.sv
module sram_bus_ctrl
  import sram_ctrl_pkg::*;
#(
  parameter int ADDR_W     = 18,
  parameter int DATA_W     = 8,
  parameter int CLK_PS     = 10000,
  parameter int T_RELEASE_PS = 4000,
  parameter int T_PULSE_PS   = 7000,
  parameter int T_DSETUP_PS  = 5000,
  parameter int T_AWEND_PS   = 8000,
  parameter int T_ACCESS_PS  = 10000
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              reqValid,
  output logic              reqReady,
  input  logic              reqWrite,
  input  logic [ADDR_W-1:0] reqAddr,
  input  logic [DATA_W-1:0] reqWdata,
  output logic              rspValid,
  output logic [DATA_W-1:0] rspData,
  output logic [ADDR_W-1:0] sramAddr,
  output logic              sramCeN,
  output logic              sramOeN,
  output logic              sramWeN,
  output logic [DATA_W-1:0] sramDqOut,
  output logic              sramDqOe,
  input  logic [DATA_W-1:0] sramDqIn
);

  localparam int TURN_CYC  = (cyclesFor(T_RELEASE_PS, CLK_PS) < 1) ? 1 : cyclesFor(T_RELEASE_PS, CLK_PS);
  localparam int PULSE_MIN = cyclesFor(T_PULSE_PS, CLK_PS);
  localparam int DRIVE_MIN = TURN_CYC + cyclesFor(T_DSETUP_PS, CLK_PS);
  localparam int WE_CYC    = (PULSE_MIN > DRIVE_MIN) ? PULSE_MIN : DRIVE_MIN;
  localparam int SETUP_RAW = cyclesFor(T_AWEND_PS, CLK_PS) - WE_CYC;
  localparam int SETUP_CYC = (SETUP_RAW < 1) ? 1 : SETUP_RAW;
  localparam int RD_CYC    = cyclesFor(T_ACCESS_PS, CLK_PS) + 1;

  dpStrobe_t strobe;

  sram_ctrl_fsm #(
    .SETUP_CYC(SETUP_CYC), .WE_CYC(WE_CYC), .TURN_CYC(TURN_CYC), .RD_CYC(RD_CYC)
  ) fsm_i (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqWrite(reqWrite),
    .reqReady(reqReady), .sramCeN(sramCeN), .sramOeN(sramOeN),
    .sramWeN(sramWeN), .strobe(strobe)
  );

  sram_ctrl_datapath #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) dp_i (
    .clk(clk), .rstN(rstN), .strobe(strobe), .reqAddr(reqAddr),
    .reqWdata(reqWdata), .sramDqIn(sramDqIn), .sramAddr(sramAddr),
    .sramDqOut(sramDqOut), .sramDqOe(sramDqOe), .rspValid(rspValid),
    .rspData(rspData)
  );

  // R8: address holds while the memory stays selected
  assert_addr_stable_R8: assert property (@(posedge clk) disable iff (!rstN)
    (!sramCeN && $past(!sramCeN)) |-> $stable(sramAddr));

  // R4: drivers on only inside the selected write pulse
  assert_drive_window_R4: assert property (@(posedge clk) disable iff (!rstN)
    sramDqOe |-> (!sramWeN && !sramCeN));

  // R4: drivers released on the edge that ends the write
  assert_drive_release_R4: assert property (@(posedge clk) disable iff (!rstN)
    $rose(sramWeN) |-> !sramDqOe);

endmodule

// File: tb/sram_bus_ctrl_tb_top.sv
module sram_bus_ctrl_tb_top;

  localparam int CLK_PS = 8000;
  // R9: expected counts at an 8 ns clock
  localparam int SETUP_CYC = 1;
  localparam int WE_CYC    = 2;
  localparam int TURN_CYC  = 1;
  localparam int RD_CYC    = 3;

  logic        clk = 1'b0;
  logic        rstN;
  logic        reqValid, reqReady, reqWrite;
  logic [17:0] reqAddr;
  logic [7:0]  reqWdata;
  logic        rspValid;
  logic [7:0]  rspData;
  logic [17:0] sramAddr;
  logic        sramCeN, sramOeN, sramWeN, sramDqOe;
  logic [7:0]  sramDqOut, sramDqIn;

  int errors = 0;
  int checks = 0;
  int cycleCount = 0;

  always #4 clk = ~clk;

  sram_bus_ctrl #(.CLK_PS(CLK_PS)) dut_i (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqReady(reqReady),
    .reqWrite(reqWrite), .reqAddr(reqAddr), .reqWdata(reqWdata),
    .rspValid(rspValid), .rspData(rspData), .sramAddr(sramAddr),
    .sramCeN(sramCeN), .sramOeN(sramOeN), .sramWeN(sramWeN),
    .sramDqOut(sramDqOut), .sramDqOe(sramDqOe), .sramDqIn(sramDqIn)
  );

  // memory behind the pins (low 8 address bits)
  logic [7:0] pinMem [256];
  logic [7:0] refMem [256];
  initial for (int i = 0; i < 256; i++) begin
    pinMem[i] = 8'(i) ^ 8'h5A;
    refMem[i] = 8'(i) ^ 8'h5A;
  end
  assign sramDqIn = (!sramCeN && !sramOeN) ? pinMem[sramAddr[7:0]] : 8'hEE;
  always @(posedge clk)
    if (!sramCeN && !sramWeN && sramDqOe) pinMem[sramAddr[7:0]] = sramDqOut;

  // reference model: one expected entry per cycle
  typedef struct {
    bit rdy; bit ce; bit oe; bit we; bit drv; bit rv;
    logic [17:0] a; logic [7:0] d; int tag;
  } exp_t;
  exp_t q[$];

  function automatic exp_t mk(bit rdy, bit ce, bit oe, bit we, bit drv, bit rv,
                               logic [17:0] a, logic [7:0] d, int tag);
    exp_t e;
    e.rdy = rdy; e.ce = ce; e.oe = oe; e.we = we; e.drv = drv; e.rv = rv;
    e.a = a; e.d = d; e.tag = tag;
    return e;
  endfunction

  always @(posedge clk) begin
    cycleCount++;
    if (!rstN) q.delete();
    else if (q.size() > 0) void'(q.pop_front());
    else if (reqValid) begin
      if (reqWrite) begin
        for (int i = 0; i < SETUP_CYC; i++) q.push_back(mk(0,0,1,1,0,0,reqAddr,reqWdata,3));
        for (int i = 0; i < WE_CYC; i++) q.push_back(mk(0,0,1,0,(i >= TURN_CYC),0,reqAddr,reqWdata,4));
        q.push_back(mk(0,1,1,1,0,0,reqAddr,reqWdata,7));
        refMem[reqAddr[7:0]] = reqWdata;
      end else begin
        for (int i = 0; i < RD_CYC; i++) q.push_back(mk(0,0,0,1,0,0,reqAddr,8'h00,5));
        q.push_back(mk(0,1,1,1,0,1,reqAddr,refMem[reqAddr[7:0]],6));
      end
    end
  end

  // compare every cycle at the falling edge (R8: address checked while selected)
  always @(negedge clk) begin
    exp_t e;
    bit bad;
    e = (q.size() > 0) ? q[0] : mk(1,1,1,1,0,0,18'h0,8'h0, rstN ? 2 : 1);
    bad = (reqReady != e.rdy) || (sramCeN != e.ce) || (sramOeN != e.oe) ||
          (sramWeN != e.we) || (sramDqOe != e.drv) || (rspValid != e.rv) ||
          (!e.ce && sramAddr != e.a) || (e.drv && sramDqOut != e.d) ||
          (e.rv && rspData != e.d);
    checks++;
    if (bad) begin
      errors++;
      $display("FAIL R%0d t=%0t actual rdy=%b ce=%b oe=%b we=%b oe_dq=%b rv=%b a=%h dq=%h rd=%h expected rdy=%b ce=%b oe=%b we=%b oe_dq=%b rv=%b a=%h d=%h",
               e.tag, $time, reqReady, sramCeN, sramOeN, sramWeN, sramDqOe, rspValid,
               sramAddr, sramDqOut, rspData, e.rdy, e.ce, e.oe, e.we, e.drv, e.rv, e.a, e.d);
    end
  end

  // watchdog
  always @(posedge clk) if (cycleCount > 100000) begin
    errors++; checks++;
    $display("FAIL R2 watchdog actual=running expected=finished");
    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  // called at a falling edge; returns at the falling edge after acceptance
  task automatic issue(input bit wr, input logic [17:0] a, input logic [7:0] d);
    reqValid = 1'b1; reqWrite = wr; reqAddr = a; reqWdata = d;
    while (!reqReady) @(negedge clk);
    @(negedge clk);
  endtask

  task automatic idle(input int n);
    reqValid = 1'b0; reqAddr = 18'h2AAAA; reqWdata = 8'hC3;
    repeat (n) @(negedge clk);
  endtask

  initial begin
    rstN = 1'b0; reqValid = 1'b0; reqWrite = 1'b0; reqAddr = '0; reqWdata = '0;
    repeat (3) @(negedge clk);   // R1: reset state checked each cycle
    rstN = 1'b1;
    @(negedge clk);
    // R3 R4: single write, then R5 R6: read it back through the pins
    issue(1'b1, 18'h3FF10, 8'hA5); idle(8);
    issue(1'b0, 18'h3FF10, 8'h00); idle(8);
    // R6: read of an untouched location
    issue(1'b0, 18'h00022, 8'h00); idle(3);
    // R2 R7: back-to-back writes with valid held; fields change while busy
    issue(1'b1, 18'h00001, 8'h11);
    issue(1'b1, 18'h3FFFF, 8'hFF);
    issue(1'b1, 18'h00080, 8'h00);
    // R7 R8: back-to-back reads directly after writes
    issue(1'b0, 18'h00001, 8'h99);
    issue(1'b0, 18'h3FFFF, 8'h99);
    issue(1'b0, 18'h00080, 8'h99);
    // mixed write/read to the same location
    issue(1'b1, 18'h12345, 8'h3C);
    issue(1'b0, 18'h12345, 8'h00);
    idle(10);
    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule